// File: doc/BRIEF.md
# Four-Channel Multi-Mode PWM Generator

This block drives a set of pulse-width-modulated pins, four by default, from one clock. Every channel owns a counter, a period value and a duty value. The counter can run in one of two ways. In the saw-tooth way it counts up and wraps. In the triangle way it climbs to the period and then falls back. A channel can also be set to fire a single period and then stop on its own. Channel 0 can be gated by channel 1, which gives bursts of pulses. The active level of every pin can be chosen, and every channel raises a flag at the end of each period.

Software reaches the block through a write-only port. The address carries the channel number in its upper bits and a register index in its two lowest bits. The counters advance only on cycles where the prescaler tick input is high. The output frequency is therefore the tick rate divided by the period length. A wider period gives finer duty steps at a lower output rate. The period and duty values written by software are held in shadow registers. They take effect only when the counter returns to zero, or at once while the channel is stopped.

Top module: `pwm_quad`

## Requirements
- R1: After reset every pin is low, every interrupt flag is clear and every channel is stopped.
- R2: Register index 0 is the control word, with bit0 run, bit1 triangle mode, bit2 active-low, bit3 single period and bit4 burst. Index 1 is the period P and index 2 is the duty D. The address is {channel, index[1:0]}. In saw-tooth mode a running channel counts 0..P-1 on ticks, and its pin is active while the count is below D.
- R3: In triangle mode the count runs 0,1..P,P-1..1 and then returns to 0, so one period lasts 2P ticks. The pin is active while the count is below D, which gives 2D-1 active ticks per period for 0<D<P.
- R4: A duty of 0 keeps the pin inactive for the whole period. A duty at or above P keeps it active for the whole period.
- R5: Control bit2 set makes the active level low. A stopped channel holds its pin at the inactive level, which is high when bit2 is set.
- R6: Period and duty writes to a running channel take effect only when the count returns to 0. The period in progress keeps its old values.
- R7: With control bit3 set, the channel completes exactly one period. Its run bit is then cleared by hardware and the pin stays inactive.
- R8: With control bit4 set on channel 0, its pin is active only while both channel 0 and channel 1 are active.
- R9: A channel's flag sets on the tick where its count returns to 0. A write with bit0 set to index 3 of that channel clears it. A write of 0 there leaves it set.
- R10: Without a tick, the counters, the pins and the flags do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Prescaler enable; counters step on cycles where it is high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | {channel[1:0], register index[1:0]} |
| wr_data | input | 16 | Write data |
| pwm_out | output | 4 | PWM pins, one per channel |
| irq | output | 4 | Period-end flags, one per channel |

## Verification
The hardest case to reach from the ports is a duty write that arrives in the middle of a running period. The bench starts the channel from a known zero count and counts cycles so that the write lands at count 3. It then measures the active cycles in the rest of that period and in the whole next period. The single-period stop also needs care. The bench can only see it indirectly, by watching that the pin stays quiet for well past the point where a second pulse would have begun.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
   // control word, bit0 is run
   typedef struct packed {
      logic burst;
      logic single;
      logic pol;
      logic center;
      logic run;
   } pwm_ctrl_t;

   localparam int CTRL_W = 5;

   localparam logic [1:0] IDX_CTRL = 2'd0;
   localparam logic [1:0] IDX_PER  = 2'd1;
   localparam logic [1:0] IDX_DUTY = 2'd2;
   localparam logic [1:0] IDX_CLR  = 2'd3;
endpackage

// File: rtl/pwm_chan_regs.sv
module pwm_chan_regs
   import pwm_pkg::*;
#(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sel,
   input  logic [1:0]    idx,
   input  logic [CW-1:0] wdata,
   input  logic          wrap,
   output pwm_ctrl_t     ctrl,
   output logic [CW-1:0] per_sh,
   output logic [CW-1:0] duty_sh,
   output logic          flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl    <= '0;
         per_sh  <= '0;
         duty_sh <= '0;
      end else begin
         if (sel && idx == IDX_CTRL)
            ctrl <= pwm_ctrl_t'(wdata[CTRL_W-1:0]);
         else if (wrap && ctrl.single)
            ctrl.run <= 1'b0;
         if (sel && idx == IDX_PER)
            per_sh <= wdata;
         if (sel && idx == IDX_DUTY)
            duty_sh <= wdata;
      end
   end

   // setting wins over a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag <= 1'b0;
      else if (wrap)
         flag <= 1'b1;
      else if (sel && idx == IDX_CLR && wdata[0])
         flag <= 1'b0;
   end
endmodule

// File: rtl/pwm_chan_core.sv
module pwm_chan_core #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          run,
   input  logic          center,
   input  logic [CW-1:0] per_sh,
   input  logic [CW-1:0] duty_sh,
   output logic          active,
   output logic          wrap
);
   logic [CW-1:0] cnt;
   logic [CW-1:0] per_act;
   logic [CW-1:0] duty_act;
   logic          down;
   logic          at_end;

   always_comb begin
      if (per_act <= CW'(1))
         at_end = 1'b1;
      else if (!center)
         at_end = (cnt >= per_act - CW'(1));
      else
         at_end = down && (cnt <= CW'(1));
   end

   assign wrap = run && tick && at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         down     <= 1'b0;
         per_act  <= '0;
         duty_act <= '0;
      end else if (!run) begin
         cnt      <= '0;
         down     <= 1'b0;
         per_act  <= per_sh;
         duty_act <= duty_sh;
      end else if (tick) begin
         if (at_end) begin
            cnt      <= '0;
            down     <= 1'b0;
            per_act  <= per_sh;
            duty_act <= duty_sh;
         end else if (!center) begin
            cnt <= cnt + CW'(1);
         end else if (!down) begin
            if (cnt == per_act) begin
               down <= 1'b1;
               cnt  <= cnt - CW'(1);
            end else begin
               cnt <= cnt + CW'(1);
            end
         end else begin
            cnt <= cnt - CW'(1);
         end
      end
   end

   assign active = run && (duty_act != '0) &&
                   ((duty_act >= per_act) || (cnt < duty_act));
endmodule

// File: rtl/pwm_pin_stage.sv
module pwm_pin_stage #(
   parameter int NCH = 4
) (
   input  logic [NCH-1:0] act,
   input  logic [NCH-1:0] pol,
   input  logic           burst0,
   output logic [NCH-1:0] pin
);
   logic [NCH-1:0] gated;

   for (genvar c = 0; c < NCH; c++) begin : g_pin
      if (c == 0) begin : g_gate
         assign gated[c] = act[0] && (!burst0 || act[1]);
      end else begin : g_pass
         assign gated[c] = act[c];
      end
      assign pin[c] = gated[c] ^ pol[c];
   end
endmodule

// File: rtl/pwm_quad.sv
module pwm_quad
   import pwm_pkg::*;
#(
   parameter int NCH    = 4,
   parameter int CW     = 16,
   localparam int CH_W   = $clog2(NCH),
   localparam int ADDR_W = CH_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CW-1:0]     wr_data,
   output logic [NCH-1:0]    pwm_out,
   output logic [NCH-1:0]    irq
);
   if (NCH < 2 || NCH > 16) begin : g_bad_nch
      $error("pwm_quad: NCH must lie in 2..16");
   end
   if (CW < CTRL_W) begin : g_bad_cw
      $error("pwm_quad: CW must hold the control word");
   end

   pwm_ctrl_t      ctrl [NCH];
   logic [NCH-1:0] act_v;
   logic [NCH-1:0] pol_v;
   logic [NCH-1:0] wrap_v;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic          sel;
      logic [CW-1:0] per_sh;
      logic [CW-1:0] duty_sh;

      assign sel = wr_en && (wr_addr[ADDR_W-1:2] == CH_W'(c));

      pwm_chan_regs #(.CW(CW)) u_regs (
         .clk    (clk),
         .rst_n  (rst_n),
         .sel    (sel),
         .idx    (wr_addr[1:0]),
         .wdata  (wr_data),
         .wrap   (wrap_v[c]),
         .ctrl   (ctrl[c]),
         .per_sh (per_sh),
         .duty_sh(duty_sh),
         .flag   (irq[c])
      );

      pwm_chan_core #(.CW(CW)) u_core (
         .clk    (clk),
         .rst_n  (rst_n),
         .tick   (tick),
         .run    (ctrl[c].run),
         .center (ctrl[c].center),
         .per_sh (per_sh),
         .duty_sh(duty_sh),
         .active (act_v[c]),
         .wrap   (wrap_v[c])
      );

      assign pol_v[c] = ctrl[c].pol;
   end

   pwm_pin_stage #(.NCH(NCH)) u_pins (
      .act   (act_v),
      .pol   (pol_v),
      .burst0(ctrl[0].burst),
      .pin   (pwm_out)
   );
endmodule

// File: rtl/pwm_quad_chk.sv
module pwm_quad_chk #(
   parameter int NCH    = 4,
   parameter int ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic              wr_lsb,
   input logic [NCH-1:0]    pwm_out,
   input logic [NCH-1:0]    irq
);
   localparam int CH_W = ADDR_W - 2;

   // R10
   pins_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !wr_en) |=> $stable(pwm_out));

   // R10
   flag_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> ((irq & ~$past(irq)) == '0));

   for (genvar c = 0; c < NCH; c++) begin : g_flag
      logic clr;
      assign clr = wr_en && wr_lsb && (wr_addr[1:0] == 2'd3) &&
                   (wr_addr[ADDR_W-1:2] == CH_W'(c));

      // R9
      flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (clr && !tick) |=> !irq[c]);

      // R9
      flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (irq[c] && !clr) |=> irq[c]);
   end
endmodule

bind pwm_quad pwm_quad_chk #(.NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .tick   (tick),
   .wr_en  (wr_en),
   .wr_addr(wr_addr),
   .wr_lsb (wr_data[0]),
   .pwm_out(pwm_out),
   .irq    (irq)
);

// File: tb/test_pwm_quad.sv
module test_pwm_quad;
   localparam int CLK_PERIOD = 10;
   localparam int NCH = 4;
   localparam int CW = 16;
   localparam int ADDR_W = 4;

   typedef struct packed {
      logic        center;
      logic        pol;
      logic [15:0] per;
      logic [15:0] duty;
      logic [15:0] win;
      logic [15:0] expc;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 1'b0, 16'd8,  16'd3, 16'd8,  16'd3},
      '{1'b0, 1'b0, 16'd8,  16'd0, 16'd8,  16'd0},
      '{1'b0, 1'b0, 16'd8,  16'd8, 16'd8,  16'd8},
      '{1'b0, 1'b0, 16'd5,  16'd9, 16'd5,  16'd5},
      '{1'b0, 1'b1, 16'd10, 16'd4, 16'd10, 16'd4},
      '{1'b1, 1'b0, 16'd6,  16'd3, 16'd12, 16'd5},
      '{1'b1, 1'b0, 16'd6,  16'd6, 16'd12, 16'd12},
      '{1'b1, 1'b1, 16'd4,  16'd1, 16'd8,  16'd1},
      '{1'b1, 1'b0, 16'd5,  16'd0, 16'd10, 16'd0}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              tick = 1'b1;
   logic              wr_en = 1'b0;
   logic [ADDR_W-1:0] wr_addr = '0;
   logic [CW-1:0]     wr_data = '0;
   logic [NCH-1:0]    pwm_out;
   logic [NCH-1:0]    irq;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pwm_quad #(.NCH(NCH), .CW(CW)) i_pwm_quad (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .wr_en  (wr_en),
      .wr_addr(wr_addr),
      .wr_data(wr_data),
      .pwm_out(pwm_out),
      .irq    (irq)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // called at a negedge, returns at the next negedge
   task automatic wr(input int ch, input int idx, input int val);
      wr_en   = 1'b1;
      wr_addr = ADDR_W'((ch << 2) | idx);
      wr_data = CW'(val);
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic count_act(input int ch, input logic pol, input int n, output int hits);
      hits = 0;
      for (int i = 0; i < n; i++) begin
         if (pwm_out[ch] == ~pol) hits++;
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual 0 expected 1");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      int h;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1
      chk("R1 pins after reset", int'(pwm_out), 0);
      chk("R1 flags after reset", int'(irq), 0);

      // R5 stopped channel with active-low sits high
      wr(2, 0, 4);
      chk("R5 stopped active-low pin", int'(pwm_out[2]), 1);

      // R2 R3 R4 R5 vector table on channel 2
      for (int k = 0; k < NV; k++) begin
         wr(2, 0, 0);
         wr(2, 1, int'(VECS[k].per));
         wr(2, 2, int'(VECS[k].duty));
         wr(2, 0, 1 | (int'(VECS[k].center) << 1) | (int'(VECS[k].pol) << 2));
         count_act(2, VECS[k].pol, int'(VECS[k].win), h);
         chk($sformatf("R2 R3 R4 R5 vector %0d", k), h, int'(VECS[k].expc));
      end
      wr(2, 0, 0);

      // R9 flag timing and clear on channel 3
      wr(3, 1, 8);
      wr(3, 2, 2);
      wr(3, 0, 1);
      repeat (7) @(negedge clk);
      chk("R9 flag before period end", int'(irq[3]), 0);
      @(negedge clk);
      chk("R9 flag at period end", int'(irq[3]), 1);
      wr(3, 3, 0);
      chk("R9 write of zero keeps flag", int'(irq[3]), 1);
      wr(3, 3, 1);
      chk("R9 write of one clears flag", int'(irq[3]), 0);

      // R6 duty change mid-period on channel 3
      wr(3, 0, 0);
      wr(3, 1, 8);
      wr(3, 2, 2);
      wr(3, 0, 1);
      count_act(3, 1'b0, 3, h);
      chk("R6 first part of period", h, 2);
      wr(3, 2, 6);
      count_act(3, 1'b0, 4, h);
      chk("R6 old duty kept to period end", h, 0);
      count_act(3, 1'b0, 8, h);
      chk("R6 new duty in next period", h, 6);
      wr(3, 0, 0);

      // R7 single period on channel 2
      wr(2, 3, 1);
      wr(2, 1, 4);
      wr(2, 2, 2);
      wr(2, 0, 1 | 8);
      count_act(2, 1'b0, 12, h);
      chk("R7 one pulse then stop", h, 2);
      chk("R7 flag raised once", int'(irq[2]), 1);
      count_act(2, 1'b0, 10, h);
      chk("R7 stays inactive", h, 0);

      // R8 burst gating of channel 0 by channel 1
      wr(1, 1, 8);
      wr(1, 2, 4);
      wr(1, 0, 1);
      wr(0, 1, 4);
      wr(0, 2, 4);
      wr(0, 0, 1 | 16);
      count_act(0, 1'b0, 8, h);
      chk("R8 burst gated count", h, 4);
      wr(0, 0, 1);
      count_act(0, 1'b0, 8, h);
      chk("R8 ungated count", h, 8);
      wr(1, 0, 0);
      count_act(0, 1'b0, 4, h);
      chk("R8 ungated ignores channel 1", h, 4);
      wr(0, 0, 1 | 16);
      count_act(0, 1'b0, 4, h);
      chk("R8 gate closed when channel 1 stopped", h, 0);
      wr(0, 0, 0);

      // R10 no tick, no progress
      wr(3, 3, 1);
      wr(3, 1, 4);
      wr(3, 2, 2);
      tick = 1'b0;
      wr(3, 0, 1);
      count_act(3, 1'b0, 10, h);
      chk("R10 pin held without tick", h, 10);
      chk("R10 flag held without tick", int'(irq[3]), 0);
      tick = 1'b1;
      count_act(3, 1'b0, 4, h);
      chk("R10 resumes with tick", h, 2);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule